// File: doc/BRIEF.md
# Target Bus Ownership Controller

This controller lets a supervising agent take the external memory bus away from a target processor and give it back. It also decides whether the target is held in reset. Two active-low outputs drive the target: reset and bus request. The bus-acknowledge input comes from the target and is synchronised before use. A command arrives as a single-cycle strobe with a 3-bit code. The controller reports which of four ownership states it is in. The target can be kept in reset while the supervisor owns its bus, so memory can be loaded before the target executes its first instruction.

Ownership decides the output enables. The supervisor's address, data and strobe drivers may drive only while the bus is owned. When ownership is gained, the strobe lines are first parked at their inactive-high level. The output enables follow one cycle later. A free-running tick input bounds how long the controller waits for acknowledge, and a clock-cycle count sets the reset pulse width. An operation that takes time (an acknowledge wait, a reset pulse, a request gap) raises a busy flag. While busy is high, only the reset command is accepted.

Top module: `bus_acq_ctrl`

## Requirements
- R1: Out of reset the state is 0, the target reset output is low, bus request is high, strb_idle, bus_oe and busy are low. The state encoding is 0 = target held in reset, 1 = held in reset with bus owned, 2 = target running, 3 = running with bus owned.
- R2: Command code 0 (reset) is accepted in any state and while busy. One cycle later the state is 0, target reset is low, bus request is high and both enables are off.
- R3: Command code 1 (request) in state 0 raises target reset, lowers bus request and sets busy. A synchronised acknowledge moves the state to 1 with the bus enabled. A timeout instead lowers target reset again, raises bus request and leaves the state at 0.
- R4: Request in state 2 lowers bus request and sets busy. Acknowledge moves the state to 3. A timeout raises bus request and the state stays 2.
- R5: An acknowledge wait expires in the cycle that carries the TIMEOUT_TICKS-th tick pulse seen during the wait. An acknowledge sampled in that same cycle takes precedence.
- R6: Command code 2 (release) moves state 1 to 0, with target reset low again. It moves state 3 to 2. In both cases bus request goes high and the enables go off.
- R7: Command code 3 (run) moves state 0 to 2 by raising target reset. From state 1 it disables the bus and holds target reset low for PULSE_CYCLES cycles. It then enters state 3 with the bus re-enabled.
- R8: Command code 4 (restart) in state 2 or 3 drives target reset low for exactly PULSE_CYCLES cycles and leaves the state unchanged.
- R9: Command code 5 (memory cycle) in state 3 disables the bus and raises bus request for GAP_CYCLES cycles, then waits for acknowledge again. Acknowledge keeps state 3 and re-enables the bus. A timeout raises bus request and moves the state to 2.
- R10: strb_idle rises one cycle before bus_oe, and bus_oe is never high without strb_idle. Both fall together.
- R11: A command that has no meaning in the current state is ignored. So are codes 6 and 7, and every non-reset command given while busy.
- R12: ack_n passes through a SYNC_STAGES-flop synchroniser before the controller acts on it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | One-cycle pulse of the slow timeout time base |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_code | input | 3 | Command code (0 reset, 1 request, 2 release, 3 run, 4 restart, 5 memory cycle) |
| ack_n | input | 1 | Bus acknowledge from target, active low, asynchronous |
| state | output | 2 | Ownership state |
| tgt_rst_n | output | 1 | Target reset, active low |
| bus_req_n | output | 1 | Bus request to target, active low |
| strb_idle | output | 1 | Park strobe lines at their inactive-high level |
| bus_oe | output | 1 | Output enable for address, data and strobe drivers |
| busy | output | 1 | A timed operation is in progress |

## Verification
The bench plays the target. In some runs it answers bus request after a short delay, and in others it never answers, which forces the timeout paths out of states 0, 2 and 3. A design that left target reset released after a failed request from state 0 would leave the target running with no owner. A design that kept state 3 after a memory-cycle timeout would report ownership it no longer has. The bench also sends commands that are invalid in the current state, reserved codes, and commands issued while a reset pulse or an acknowledge wait is in progress. A design that honoured any of these would change the state or the target lines, and the per-cycle comparison would catch it. A reset command given in the middle of an acknowledge wait must abort the wait at once. The reset pulse width is compared cycle by cycle, so a pulse that is one cycle long or short is caught.

// File: rtl/bac_pkg.sv
package bac_pkg;
  localparam logic [2:0] CMD_RESET   = 3'd0;
  localparam logic [2:0] CMD_REQUEST = 3'd1;
  localparam logic [2:0] CMD_RELEASE = 3'd2;
  localparam logic [2:0] CMD_RUN     = 3'd3;
  localparam logic [2:0] CMD_RESTART = 3'd4;
  localparam logic [2:0] CMD_MCYCLE  = 3'd5;

  localparam logic [1:0] ST_HELD     = 2'd0;
  localparam logic [1:0] ST_HELD_OWN = 2'd1;
  localparam logic [1:0] ST_RUN      = 2'd2;
  localparam logic [1:0] ST_RUN_OWN  = 2'd3;

  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_WAIT  = 2'd1,
    PH_PULSE = 2'd2,
    PH_GAP   = 2'd3
  } phase_e;
endpackage

// File: rtl/bac_sync.sv
module bac_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] sr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr_q <= {STAGES{RST_VAL}};
    else        sr_q <= {sr_q[STAGES-2:0], d};
  end

  assign q = sr_q[STAGES-1];
endmodule

// File: rtl/bac_cnt.sv
module bac_cnt #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold,
  input  logic step,
  output logic hit
);
  localparam int CW = (LIMIT < 2) ? 1 : $clog2(LIMIT + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt_q <= '0;
    else if (hold) cnt_q <= '0;
    else if (step) cnt_q <= cnt_q + 1'b1;
  end

  assign hit = step && (cnt_q == CW'(LIMIT - 1));
endmodule

// File: rtl/bus_acq_ctrl.sv
module bus_acq_ctrl
  import bac_pkg::*;
#(
  parameter int TIMEOUT_TICKS = 20,
  parameter int PULSE_CYCLES  = 2500,
  parameter int GAP_CYCLES    = 2,
  parameter int SYNC_STAGES   = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       cmd_valid,
  input  logic [2:0] cmd_code,
  input  logic       ack_n,
  output logic [1:0] state,
  output logic       tgt_rst_n,
  output logic       bus_req_n,
  output logic       strb_idle,
  output logic       bus_oe,
  output logic       busy
);
  logic   rst_core_n;
  logic   ack_s_n;
  logic   to_hit, pl_hit, gp_hit;
  logic   in_wait, in_pulse, in_gap;

  logic [1:0] st_q, st_d;
  phase_e     ph_q, ph_d;
  logic       trst_q, trst_d;
  logic       breq_q, breq_d;
  logic       own_q, own_d;
  logic       oe_q, oe_d;

  // reset: asserted asynchronously, released on a clock edge
  bac_sync #(.STAGES(2), .RST_VAL(1'b0)) u_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_core_n)
  );

  bac_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_ack_sync (
    .clk(clk), .rst_n(rst_core_n), .d(ack_n), .q(ack_s_n)
  );

  assign in_wait  = (ph_q == PH_WAIT);
  assign in_pulse = (ph_q == PH_PULSE);
  assign in_gap   = (ph_q == PH_GAP);

  bac_cnt #(.LIMIT(TIMEOUT_TICKS)) u_to_cnt (
    .clk(clk), .rst_n(rst_core_n), .hold(!in_wait), .step(in_wait && tick), .hit(to_hit)
  );
  bac_cnt #(.LIMIT(PULSE_CYCLES)) u_pl_cnt (
    .clk(clk), .rst_n(rst_core_n), .hold(!in_pulse), .step(in_pulse), .hit(pl_hit)
  );
  bac_cnt #(.LIMIT(GAP_CYCLES)) u_gp_cnt (
    .clk(clk), .rst_n(rst_core_n), .hold(!in_gap), .step(in_gap), .hit(gp_hit)
  );

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    trst_d = trst_q;
    breq_d = breq_q;
    own_d  = own_q;
    if (cmd_valid && cmd_code == CMD_RESET) begin
      st_d   = ST_HELD;
      ph_d   = PH_IDLE;
      trst_d = 1'b0;
      breq_d = 1'b1;
      own_d  = 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: begin
          if (cmd_valid) begin
            case (cmd_code)
              CMD_REQUEST: begin
                if (st_q == ST_HELD || st_q == ST_RUN) begin
                  trst_d = 1'b1;
                  breq_d = 1'b0;
                  ph_d   = PH_WAIT;
                end
              end
              CMD_RELEASE: begin
                if (st_q[0]) begin
                  breq_d = 1'b1;
                  own_d  = 1'b0;
                  st_d   = st_q & 2'b10;
                  if (st_q == ST_HELD_OWN) trst_d = 1'b0;
                end
              end
              CMD_RUN: begin
                if (st_q == ST_HELD) begin
                  trst_d = 1'b1;
                  st_d   = ST_RUN;
                end else if (st_q == ST_HELD_OWN) begin
                  own_d  = 1'b0;
                  trst_d = 1'b0;
                  ph_d   = PH_PULSE;
                end
              end
              CMD_RESTART: begin
                if (st_q[1]) begin
                  trst_d = 1'b0;
                  ph_d   = PH_PULSE;
                end
              end
              CMD_MCYCLE: begin
                if (st_q == ST_RUN_OWN) begin
                  own_d  = 1'b0;
                  breq_d = 1'b1;
                  ph_d   = PH_GAP;
                end
              end
              default: ;
            endcase
          end
        end
        PH_WAIT: begin
          if (!ack_s_n) begin
            own_d = 1'b1;
            st_d  = st_q | 2'b01;
            ph_d  = PH_IDLE;
          end else if (to_hit) begin
            breq_d = 1'b1;
            if (st_q == ST_HELD) trst_d = 1'b0;
            st_d = st_q & 2'b10;
            ph_d = PH_IDLE;
          end
        end
        PH_PULSE: begin
          if (pl_hit) begin
            trst_d = 1'b1;
            ph_d   = PH_IDLE;
            if (st_q == ST_HELD_OWN) begin
              st_d  = ST_RUN_OWN;
              own_d = 1'b1;
            end
          end
        end
        PH_GAP: begin
          if (gp_hit) begin
            breq_d = 1'b0;
            ph_d   = PH_WAIT;
          end
        end
        default: ;
      endcase
    end
    // enables trail the strobe parking by one cycle, drop together with it
    oe_d = own_d && own_q;
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      st_q   <= ST_HELD;
      ph_q   <= PH_IDLE;
      trst_q <= 1'b0;
      breq_q <= 1'b1;
      own_q  <= 1'b0;
      oe_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      ph_q   <= ph_d;
      trst_q <= trst_d;
      breq_q <= breq_d;
      own_q  <= own_d;
      oe_q   <= oe_d;
    end
  end

  assign state     = st_q;
  assign tgt_rst_n = trst_q;
  assign bus_req_n = breq_q;
  assign strb_idle = own_q;
  assign bus_oe    = oe_q;
  assign busy      = (ph_q != PH_IDLE);
endmodule

// File: rtl/bac_checker.sv
module bac_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_valid,
  input logic [2:0] cmd_code,
  input logic [1:0] state,
  input logic       tgt_rst_n,
  input logic       bus_req_n,
  input logic       strb_idle,
  input logic       bus_oe,
  input logic       busy
);
  assert_oe_needs_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> strb_idle);

  assert_oe_lags_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strb_idle) |-> !bus_oe);

  assert_owned_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
    strb_idle |-> state[0]);

  assert_owned_has_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    strb_idle |-> !bus_req_n);

  assert_reset_cmd_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd0) |=> (state == 2'd0 && !tgt_rst_n && bus_req_n && !bus_oe));

  assert_restart_keeps_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code == 3'd4 && !busy && state[1]) |=> (state == $past(state) && !tgt_rst_n));

  assert_reserved_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_code[2:1] == 2'b11 && !busy) |=> $stable(state));
endmodule

bind bus_acq_ctrl bac_checker u_bac_checker (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .state(state), .tgt_rst_n(tgt_rst_n), .bus_req_n(bus_req_n),
  .strb_idle(strb_idle), .bus_oe(bus_oe), .busy(busy)
);

// File: tb/bus_acq_ctrl_tb_top.sv
module bus_acq_ctrl_tb_top;
  localparam int TO_T  = 4;
  localparam int PLS   = 5;
  localparam int GAP   = 3;
  localparam int TDIV  = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       tick = 1'b0;
  logic       cmd_valid = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic       ack_n = 1'b1;
  logic [1:0] state;
  logic       tgt_rst_n, bus_req_n, strb_idle, bus_oe, busy;

  int    n_cmp = 0;
  int    n_bad = 0;
  int    cyc = 0;
  bit    coop = 1'b0;
  string cur_req = "R1";
  logic [3:0] hist = 4'hF;
  int    tdiv_cnt = 0;

  // reference model state
  int m_st = 0, m_ph = 0, m_cnt = 0;
  int m_rst = 0, m_breq = 1, m_own = 0, m_oe = 0;
  int m_a1 = 1, m_a2 = 1;

  always #2 clk = ~clk;

  bus_acq_ctrl #(.TIMEOUT_TICKS(TO_T), .PULSE_CYCLES(PLS), .GAP_CYCLES(GAP)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ack_n(ack_n), .state(state), .tgt_rst_n(tgt_rst_n), .bus_req_n(bus_req_n),
    .strb_idle(strb_idle), .bus_oe(bus_oe), .busy(busy)
  );

  // behavioural reference, updated on every rising edge
  always @(posedge clk) begin
    int own_old;
    own_old = m_own;
    if (!rst_n) begin
      m_st = 0; m_ph = 0; m_cnt = 0; m_rst = 0; m_breq = 1; m_own = 0; m_oe = 0;
      m_a1 = 1; m_a2 = 1;
    end else begin
      if (cmd_valid && cmd_code == 3'd0) begin
        m_st = 0; m_ph = 0; m_rst = 0; m_breq = 1; m_own = 0;
      end else if (m_ph == 0) begin
        if (cmd_valid) begin
          if (cmd_code == 3'd1 && (m_st == 0 || m_st == 2)) begin
            m_rst = 1; m_breq = 0; m_ph = 1; m_cnt = 0;
          end else if (cmd_code == 3'd2 && (m_st == 1 || m_st == 3)) begin
            if (m_st == 1) m_rst = 0;
            m_breq = 1; m_own = 0; m_st = m_st - 1;
          end else if (cmd_code == 3'd3 && m_st == 0) begin
            m_rst = 1; m_st = 2;
          end else if (cmd_code == 3'd3 && m_st == 1) begin
            m_own = 0; m_rst = 0; m_ph = 2; m_cnt = 0;
          end else if (cmd_code == 3'd4 && m_st >= 2) begin
            m_rst = 0; m_ph = 2; m_cnt = 0;
          end else if (cmd_code == 3'd5 && m_st == 3) begin
            m_own = 0; m_breq = 1; m_ph = 3; m_cnt = 0;
          end
        end
      end else if (m_ph == 1) begin
        if (m_a2 == 0) begin
          m_own = 1; m_ph = 0;
          if (m_st == 0) m_st = 1;
          else if (m_st == 2) m_st = 3;
        end else if (tick) begin
          if (m_cnt == TO_T - 1) begin
            m_breq = 1; m_ph = 0;
            if (m_st == 0) m_rst = 0;
            if (m_st == 3) m_st = 2;
          end else m_cnt++;
        end
      end else if (m_ph == 2) begin
        if (m_cnt == PLS - 1) begin
          m_rst = 1; m_ph = 0;
          if (m_st == 1) begin m_st = 3; m_own = 1; end
        end else m_cnt++;
      end else begin
        if (m_cnt == GAP - 1) begin
          m_breq = 0; m_ph = 1; m_cnt = 0;
        end else m_cnt++;
      end
      m_oe = (m_own == 1 && own_old == 1) ? 1 : 0;
      m_a2 = m_a1;
      m_a1 = ack_n;
    end
  end

  // target behaviour and tick generator, driven away from the rising edge
  always @(negedge clk) begin
    hist = {hist[2:0], bus_req_n};
    ack_n = coop ? hist[2] : 1'b1;
    tdiv_cnt = (tdiv_cnt + 1) % TDIV;
    tick = (tdiv_cnt == 0);
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (cyc > 2) begin
      n_cmp++;
      if (state !== 2'(m_st) || tgt_rst_n !== 1'(m_rst) || bus_req_n !== 1'(m_breq) ||
          strb_idle !== 1'(m_own) || bus_oe !== 1'(m_oe) || busy !== (m_ph != 0)) begin
        n_bad++;
        $display("FAIL %s cyc %0d actual st=%0d rst=%b req=%b idle=%b oe=%b busy=%b expected st=%0d rst=%0d req=%0d idle=%0d oe=%0d busy=%0d",
                 cur_req, cyc, state, tgt_rst_n, bus_req_n, strb_idle, bus_oe, busy,
                 m_st, m_rst, m_breq, m_own, m_oe, (m_ph != 0));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_bad++;
      $display("FAIL watchdog R1 actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic send(input logic [2:0] c);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_code  = c;
    @(negedge clk);
    cmd_valid = 1'b0;
    cmd_code  = 3'd0;
  endtask

  task automatic expect_state(input int s, input string tag);
    n_cmp++;
    if (state !== 2'(s)) begin
      n_bad++;
      $display("FAIL %s actual state %0d expected %0d", tag, state, s);
    end
  endtask

  initial begin
    cur_req = "R1";
    wait_cyc(4);
    rst_n = 1'b1;
    wait_cyc(6);
    expect_state(0, "R1");

    cur_req = "R3"; coop = 1'b1;
    send(3'd1); wait_cyc(12);
    expect_state(1, "R3");

    cur_req = "R11";
    send(3'd1); wait_cyc(3);
    send(3'd4); wait_cyc(3);
    send(3'd5); wait_cyc(3);
    send(3'd6); wait_cyc(3);
    send(3'd7); wait_cyc(3);
    expect_state(1, "R11");

    cur_req = "R7";
    send(3'd3); wait_cyc(2);
    send(3'd2);                 // ignored while pulsing (R11)
    wait_cyc(PLS + 6);
    expect_state(3, "R7");

    cur_req = "R9";
    send(3'd5); wait_cyc(GAP + 14);
    expect_state(3, "R9");

    cur_req = "R8";
    send(3'd4); wait_cyc(PLS + 4);
    expect_state(3, "R8");

    cur_req = "R6";
    send(3'd2); wait_cyc(6);
    expect_state(2, "R6");

    cur_req = "R8";
    send(3'd4); wait_cyc(PLS + 4);
    expect_state(2, "R8");

    cur_req = "R4";
    send(3'd1); wait_cyc(12);
    expect_state(3, "R4");
    send(3'd2); wait_cyc(6);

    cur_req = "R5"; coop = 1'b0;
    send(3'd1); wait_cyc(TO_T * TDIV + 8);
    expect_state(2, "R5");

    cur_req = "R2";
    send(3'd0); wait_cyc(4);
    expect_state(0, "R2");

    cur_req = "R3";
    send(3'd1); wait_cyc(TO_T * TDIV + 8);
    expect_state(0, "R3");

    cur_req = "R6"; coop = 1'b1;
    send(3'd1); wait_cyc(12);
    send(3'd2); wait_cyc(6);
    expect_state(0, "R6");

    cur_req = "R2";
    send(3'd1); wait_cyc(12);
    send(3'd0); wait_cyc(4);
    expect_state(0, "R2");

    cur_req = "R7";
    send(3'd3); wait_cyc(4);
    expect_state(2, "R7");

    cur_req = "R9";
    send(3'd1); wait_cyc(12);
    coop = 1'b0;
    send(3'd5); wait_cyc(GAP + TO_T * TDIV + 10);
    expect_state(2, "R9");

    cur_req = "R12";
    coop = 1'b1;
    send(3'd1); wait_cyc(12);
    expect_state(3, "R12");

    cur_req = "R2"; coop = 1'b0;
    send(3'd2); wait_cyc(4);
    send(3'd1); wait_cyc(3);
    send(3'd0); wait_cyc(5);
    expect_state(0, "R2");

    cur_req = "R10";
    coop = 1'b1;
    send(3'd1); wait_cyc(12);
    send(3'd2); wait_cyc(6);
    expect_state(0, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule